// File: doc/BRIEF.md
# Programmable-Priority Interrupt Arbiter

The block collects 23 interrupt request lines, numbered 0 to 22. Each line has a 3-bit priority level that software sets through a bank of 16-bit registers. A request is latched into a sticky pending flag. Only pending sources that are also enabled compete for the core. Each cycle a combinational arbiter picks the winner: the highest level, with ties going to the lowest source number. The winner is offered to the processor core as a registered request, vector number and level.

A presented request is held until the core acknowledges it. Before the acknowledge it gives way only to a strictly more urgent request, and the request it displaces stays pending. The acknowledge clears the pending flag of the presented vector and drops the request output. One cycle later the arbiter presents the next winner.

The core's own level mask is modelled by a threshold input. A winner whose level is below that threshold is not offered.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every level field reads 0, no source is pending, and `intReq` is 0.
- R2: Register index k (0 to 11) holds the level of source 2k in bits [2:0] and the level of source 2k+1 in bits [10:8]. A write on `regWe` takes effect at the clock edge, and `regRdata` shows the selected register combinationally.
- R3: Bits [15:11] and [7:3] of every register read 0, and writes to them are ignored. Bits [10:8] of index 11 read 0. Indices 12 to 15 read 0, and writes to them change nothing.
- R4: A cycle with `irqIn[i]` high sets the pending flag of source i. The flag stays set, whatever later happens on `irqIn[i]`, until that vector is acknowledged.
- R5: A pending source takes part in arbitration only while its `irqEn` bit is 1. If the bit is set later, a source that is already pending competes from then on.
- R6: The presented vector is the eligible source with the highest level, and `intLvl` shows that level.
- R7: Among eligible sources of equal level, the lowest source number wins.
- R8: A winner is presented (`intReq` 1) only if its level is at least `coreLvl`. Otherwise `intReq` stays 0 until the threshold or the candidates change.
- R9: While `intReq` is 1 and no acknowledge arrives, the vector and level change only to a winner of strictly higher level. An equal-level request with a lower number does not replace the presented one.
- R10: When `intAck` is high while `intReq` is 1, `intReq` is 0 after that edge and the pending flag of the presented vector is cleared. The next winner, including any request that was displaced earlier, is presented one edge later.
- R11: The outputs are registered. A request that is sampled on `irqIn` at one edge appears on `intReq`, `intVec` and `intLvl` after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Level register index |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| irqIn | input | 23 | Request lines, one per source |
| irqEn | input | 23 | Per-source enable |
| coreLvl | input | 3 | Core level threshold |
| intAck | input | 1 | Core acknowledge of the presented request |
| intReq | output | 1 | Request to the core |
| intVec | output | 5 | Presented vector number |
| intLvl | output | 3 | Presented level |

## Verification
The hardest situation to reach is a replacement before acknowledge. It needs a request already held at the output, with no acknowledge, and then a second request arriving. The second request must come in one test at equal level with a lower number and in another at strictly higher level. The bench pulses one source and waits until it is presented. It then pulses the competitor while `intAck` stays low. It then acknowledges repeatedly to show the displaced requests come back in priority order. The threshold gate is reached by raising `coreLvl` above the only pending level and then lowering it.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  typedef struct packed {
    logic load;     // capture arbiter winner into output registers
    logic clrPend;  // clear pending flag of presented vector
  } arbStrobe_t;
endpackage

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int NUM_SRC = 23,
  parameter int LVL_W   = 3,
  parameter int DATA_W  = 16,
  parameter int ODD_LSB = 8,
  parameter int REG_AW  = 4,
  parameter int VEC_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] irqEn,
  input  logic [LVL_W-1:0]  coreLvl,
  input  arbStrobe_t        strobe,
  output logic              winValid,
  output logic [LVL_W-1:0]  winLvl,
  output logic [VEC_W-1:0]  curVec,
  output logic [LVL_W-1:0]  curLvl
);
  logic [LVL_W-1:0]   lvlQ [NUM_SRC];
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] clrMask;
  logic [VEC_W-1:0]   winVec;
  logic               winFound;

  // level register bank: two fields per register, even source low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++) lvlQ[s] <= '0;
    end else if (regWe) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (regAddr == REG_AW'(s >> 1)) begin
          if (s % 2 == 0) lvlQ[s] <= regWdata[LVL_W-1:0];
          else            lvlQ[s] <= regWdata[ODD_LSB +: LVL_W];
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (regAddr == REG_AW'(s >> 1)) begin
        if (s % 2 == 0) regRdata[LVL_W-1:0]       = lvlQ[s];
        else            regRdata[ODD_LSB +: LVL_W] = lvlQ[s];
      end
    end
  end

  // sticky pending flags
  always_comb begin
    clrMask = '0;
    if (strobe.clrPend) clrMask[curVec] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrMask) | irqIn;
  end

  // arbiter: highest level, lowest index on ties
  always_comb begin
    winFound = 1'b0;
    winLvl   = '0;
    winVec   = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pendQ[s] && irqEn[s] && (!winFound || lvlQ[s] > winLvl)) begin
        winFound = 1'b1;
        winLvl   = lvlQ[s];
        winVec   = VEC_W'(s);
      end
    end
  end

  assign winValid = winFound && (winLvl >= coreLvl);

  // presented vector / level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curVec <= '0;
      curLvl <= '0;
    end else if (strobe.load) begin
      curVec <= winVec;
      curLvl <= winLvl;
    end
  end
endmodule

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intAck,
  input  logic             winValid,
  input  logic [LVL_W-1:0] winLvl,
  input  logic [LVL_W-1:0] curLvl,
  output arbStrobe_t       strobe,
  output logic             reqQ
);
  logic ackHit;

  assign ackHit         = reqQ && intAck;
  assign strobe.clrPend = ackHit;
  assign strobe.load    = !ackHit && winValid && (!reqQ || winLvl > curLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            reqQ <= 1'b0;
    else if (ackHit)      reqQ <= 1'b0;
    else if (strobe.load) reqQ <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irqArbPkg::*;
#(
  parameter int NUM_SRC = 23,
  parameter int LVL_W   = 3,
  parameter int DATA_W  = 16,
  parameter int ODD_LSB = 8,
  localparam int NUM_REG = (NUM_SRC + 1) / 2,
  localparam int REG_AW  = $clog2(NUM_REG),
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic               regWe,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] irqEn,
  input  logic [LVL_W-1:0]   coreLvl,
  input  logic               intAck,
  output logic               intReq,
  output logic [VEC_W-1:0]   intVec,
  output logic [LVL_W-1:0]   intLvl
);
  arbStrobe_t       strobe;
  logic             winValid;
  logic [LVL_W-1:0] winLvl;

  irqArbDatapath #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W),
    .ODD_LSB(ODD_LSB), .REG_AW(REG_AW), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irqIn(irqIn),
    .irqEn(irqEn), .coreLvl(coreLvl), .strobe(strobe),
    .winValid(winValid), .winLvl(winLvl), .curVec(intVec), .curLvl(intLvl)
  );

  irqArbControl #(.LVL_W(LVL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .intAck(intAck), .winValid(winValid),
    .winLvl(winLvl), .curLvl(intLvl), .strobe(strobe), .reqQ(intReq)
  );
endmodule

// File: rtl/irqArbChecker.sv
module irqArbChecker #(
  parameter int NUM_SRC = 23,
  parameter int LVL_W   = 3,
  parameter int DATA_W  = 16,
  parameter int VEC_W   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] regRdata,
  input logic [LVL_W-1:0]  coreLvl,
  input logic              intAck,
  input logic              intReq,
  input logic [VEC_W-1:0]  intVec,
  input logic [LVL_W-1:0]  intLvl
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[15:11] == '0 && regRdata[7:3] == '0); // R3

  AST_THRESH_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> intLvl >= $past(coreLvl)); // R8

  AST_HOLD_OR_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> intReq && ((intLvl > $past(intLvl)) ||
      (intVec == $past(intVec) && intLvl == $past(intLvl)))); // R9

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> !intReq); // R10

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intVec < VEC_W'(NUM_SRC)); // R6
endmodule

bind irq_prio_arbiter irqArbChecker #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regRdata(regRdata), .coreLvl(coreLvl),
  .intAck(intAck), .intReq(intReq), .intVec(intVec), .intLvl(intLvl)
);

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [22:0] irqIn = '0;
  logic [22:0] irqEn = '1;
  logic [2:0]  coreLvl = '0;
  logic        intAck = 1'b0;
  logic        intReq;
  logic [4:0]  intVec;
  logic [2:0]  intLvl;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_arbiter dut (.*);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkOut(string tag, int req, int vec, int lvl);
    chk({tag, " req"}, int'(intReq), req);
    if (req != 0) begin
      chk({tag, " vec"}, int'(intVec), vec);
      chk({tag, " lvl"}, int'(intLvl), lvl);
    end
  endtask

  task automatic wr(int idx, int data);
    regAddr = 4'(idx); regWdata = 16'(data); regWe = 1'b1;
    step();
    regWe = 1'b0;
  endtask

  task automatic rdChk(string tag, int idx, int exp);
    regAddr = 4'(idx);
    #1;
    chk(tag, int'(regRdata), exp);
  endtask

  task automatic pulse(int src);
    irqIn[src] = 1'b1;
    step();
    irqIn[src] = 1'b0;
    step();
  endtask

  task automatic ackOnce(string tag, int req, int vec, int lvl);
    intAck = 1'b1;
    step();
    intAck = 1'b0;
    chk({tag, " drop after ack"}, int'(intReq), 0);
    step();
    chkOut(tag, req, vec, lvl);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 12; k++) rdChk("R1 reset level", k, 0);
    chk("R1 reset req", int'(intReq), 0);
    step();
    chk("R1 nothing pending", int'(intReq), 0);
  endtask

  task automatic t_regs();
    wr(0, 16'hFFFF);
    rdChk("R2 R3 reg0 fields", 0, 16'h0707);
    wr(11, 16'hFFFF);
    rdChk("R3 last upper field", 11, 16'h0007);
    wr(12, 16'hFFFF);
    rdChk("R3 index 12 reads zero", 12, 0);
    rdChk("R3 index 12 write ignored", 0, 16'h0707);
    wr(0, 0);
    wr(11, 0);
    wr(1, 16'h0500);   // src3 = 5
    wr(2, 16'h0700);   // src5 = 7
    wr(3, 16'h0200);   // src7 = 2
    wr(5, 16'h0005);   // src10 = 5
    wr(10, 16'h0006);  // src20 = 6
    rdChk("R2 odd field src3", 1, 16'h0500);
    rdChk("R2 even field src10", 5, 16'h0005);
  endtask

  task automatic t_priority();
    irqIn[3] = 1'b1; irqIn[7] = 1'b1; irqIn[10] = 1'b1;
    step();
    irqIn = '0;
    chk("R11 not yet presented", int'(intReq), 0);
    step();
    chkOut("R6 R7 tie lowest vector", 1, 3, 5);
    ackOnce("R10 next equal level", 1, 10, 5);
    ackOnce("R6 lower level after", 1, 7, 2);
    ackOnce("R10 idle when empty", 0, 0, 0);
  endtask

  task automatic t_enable();
    irqEn[5] = 1'b0;
    pulse(5);
    chk("R5 disabled ignored", int'(intReq), 0);
    irqEn[5] = 1'b1;
    step();
    chkOut("R4 R5 sticky pending enabled", 1, 5, 7);
    ackOnce("R4 cleared by ack", 0, 0, 0);
  endtask

  task automatic t_threshold();
    coreLvl = 3'd4;
    pulse(7);
    chk("R8 below threshold held", int'(intReq), 0);
    coreLvl = 3'd0;
    step();
    chkOut("R8 threshold lowered", 1, 7, 2);
    ackOnce("R8 done", 0, 0, 0);
  endtask

  task automatic t_replace();
    pulse(10);
    chkOut("R11 single request", 1, 10, 5);
    pulse(3);
    chkOut("R9 equal level no replace", 1, 10, 5);
    pulse(20);
    chkOut("R9 higher level replaces", 1, 20, 6);
    ackOnce("R10 displaced lower vec", 1, 3, 5);
    ackOnce("R10 displaced original", 1, 10, 5);
    ackOnce("R10 all served", 0, 0, 0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rstN = 1'b1;
    step();
    t_reset();
    t_regs();
    t_priority();
    t_enable();
    t_threshold();
    t_replace();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule